// File: doc/BRIEF.md
# Multi-Channel Digital Delay Pulse Core

This block turns one accepted trigger into a timing cycle measured in periods of a fast reference clock (one count is one period, 10 ns at 100 MHz). A fixed number of cycles after the trigger it raises a reference output, T0. T0 marks time zero and stays high for the whole cycle. Eight channel delays, named A to H and given as cycle counts, are measured from that point. From them the block forms four pair pulses. Each pair pulse is high from the first channel of the pair to the second, with a per-pair polarity select. The block also drives eight per-channel level outputs, eight fixed-width strobes, and four OR-combined outputs that carry two, three or four pulses per trigger.

The delay inputs are captured at the moment a trigger is accepted, so they can be rewritten freely while a cycle runs. A busy flag covers the whole cycle, from acceptance until T0 falls. A trigger that arrives while busy is dropped. A live inhibit input silences every pulse output without disturbing the cycle itself.

Top module: `dly_pulse_core`

## Requirements
- R1: A trigger is accepted only when busy_o is low. On the accepting edge busy_o rises and the eight delays are captured. Triggers that arrive while busy_o is high are ignored, and changes on dly_i during a cycle do not alter that cycle.
- R2: t0_o rises LAT_CYC clock edges after the accepting edge (default 9, which is 85 ns rounded up to whole counts). The first cycle with t0_o high is time t=0.
- R3: Let M be the largest captured delay. t0_o stays high for M+HOLD_CYC cycles (default 10, i.e. 100 ns). t0_o and busy_o fall on the same edge, and a trigger in the next cycle is accepted.
- R4: Channel n is read from dly_i[n*DW +: DW], with A=0 through H=7. Pair p (0=AB, 1=CD, 2=EF, 3=GH) uses channels 2p and 2p+1. Its pulse is high for t in [d(2p), d(2p+1)). It stays low for the whole cycle when d(2p+1) <= d(2p).
- R5: pair_o[p] equals the pulse of pair p XOR pol_i[p]. With pol_i[p]=1 the output rests high and the pulse goes low.
- R6: lvl_o[n] is high for t in [d(n), M+TAIL_CYC) (default TAIL_CYC 3, i.e. 25 ns rounded up).
- R7: stb_o[n] is high for STB_CYC cycles starting at t=d(n) (default 10, i.e. 100 ns).
- R8: The combined outputs use the non-inverted pair pulses. cmb_o[0]=AB|CD, cmb_o[1]=EF|GH, cmb_o[2]=AB|CD|EF and cmb_o[3]=AB|CD|EF|GH.
- R9: While inh_i is high, every pair, level, strobe and combined output is inactive, and pair_o equals pol_i. t0_o and busy_o are unaffected.
- R10: After reset t0_o, busy_o, lvl_o, stb_o and cmb_o are all low, and pair_o equals pol_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one delay count per period |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger strobe, sampled on each rising edge |
| dly_i | input | 8*DW | Eight channel delays in counts, channel n at bits n*DW +: DW |
| pol_i | input | 4 | Per-pair polarity, 1 = inverted |
| inh_i | input | 1 | Inhibit, forces all pulse outputs inactive |
| t0_o | output | 1 | Time-zero reference, high for the whole cycle |
| busy_o | output | 1 | High from trigger acceptance until the cycle ends |
| pair_o | output | 4 | Pair pulses AB, CD, EF, GH after polarity |
| lvl_o | output | 8 | Per-channel level outputs |
| stb_o | output | 8 | Per-channel fixed-width strobes |
| cmb_o | output | 4 | OR-combined multi-pulse outputs |

## Verification
A corrupted sequencer count shows on the next cycle edge as a T0 that is early, late or of the wrong length. A stale delay capture, or a wrong maximum, moves a pulse edge or the end of the level outputs. The bench compares every output in every cycle of every timing cycle, so such an error is reported in the same cycle it first reaches a port. Capture leaks are exposed by rewriting the delays and pulsing the trigger in the middle of a cycle. Empty pairs, a zero-delay cycle, inverted polarity and inhibit are each run as separate cycles.

// File: rtl/dly_pkg.sv
`timescale 1ns/1ps
package dly_pkg;
  localparam int NPAIR = 4;
  localparam int NCH   = 2 * NPAIR;
  localparam int NCMB  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} seq_st_e;

  // Half-open time window test shared by every output generator.
  function automatic logic in_win(input logic [31:0] t, input logic [31:0] lo,
                                  input logic [31:0] hi);
    return (t >= lo) && (t < hi);
  endfunction
endpackage

// File: rtl/dly_seq.sv
`timescale 1ns/1ps
module dly_seq import dly_pkg::*; #(
  parameter int DW       = 16,
  parameter int LAT_CYC  = 9,
  parameter int HOLD_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [NCH*DW-1:0] dly_i,
  output logic              run_o,
  output logic              busy_o,
  output logic [DW:0]       tcnt_o,
  output logic [NCH*DW-1:0] cap_o,
  output logic [DW-1:0]     maxd_o
);
  localparam int CW = DW + 1;
  localparam int LW = (LAT_CYC > 1) ? $clog2(LAT_CYC) : 1;

  seq_st_e         st;
  logic [LW-1:0]   wcnt;
  logic [CW-1:0]   tcnt;
  logic [DW-1:0]   maxd_q;
  logic [NCH*DW-1:0] cap_q;
  logic [DW-1:0]   in_max;
  logic            accept;
  logic            wait_done;
  logic            run_done;

  always_comb begin
    in_max = '0;
    for (int i = 0; i < NCH; i++)
      if (dly_i[i*DW +: DW] > in_max) in_max = dly_i[i*DW +: DW];
  end

  assign accept    = trig_i && (st == ST_IDLE);
  assign wait_done = (wcnt == LW'(LAT_CYC - 1));
  assign run_done  = ((tcnt + CW'(1)) == (CW'(maxd_q) + CW'(HOLD_CYC)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      wcnt   <= '0;
      tcnt   <= '0;
      maxd_q <= '0;
      cap_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st     <= ST_WAIT;
          wcnt   <= '0;
          cap_q  <= dly_i;
          maxd_q <= in_max;
        end
        ST_WAIT: if (wait_done) begin
          st   <= ST_RUN;
          tcnt <= '0;
        end else begin
          wcnt <= wcnt + LW'(1);
        end
        ST_RUN: if (run_done) st <= ST_IDLE;
                else          tcnt <= tcnt + CW'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (st == ST_RUN);
  assign busy_o = (st != ST_IDLE);
  assign tcnt_o = tcnt;
  assign cap_o  = cap_q;
  assign maxd_o = maxd_q;
endmodule

// File: rtl/dly_chan.sv
`timescale 1ns/1ps
module dly_chan import dly_pkg::*; #(
  parameter int DW       = 16,
  parameter int TAIL_CYC = 3,
  parameter int STB_CYC  = 10
) (
  input  logic          run_i,
  input  logic          inh_i,
  input  logic [DW:0]   tcnt_i,
  input  logic [DW-1:0] dly_i,
  input  logic [DW-1:0] maxd_i,
  output logic          lvl_o,
  output logic          stb_o
);
  logic live;
  assign live  = run_i && !inh_i;
  assign lvl_o = live && in_win(32'(tcnt_i), 32'(dly_i), 32'(maxd_i) + 32'(TAIL_CYC));
  assign stb_o = live && in_win(32'(tcnt_i), 32'(dly_i), 32'(dly_i) + 32'(STB_CYC));
endmodule

// File: rtl/dly_pair.sv
`timescale 1ns/1ps
module dly_pair import dly_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          run_i,
  input  logic          inh_i,
  input  logic          pol_i,
  input  logic [DW:0]   tcnt_i,
  input  logic [DW-1:0] lead_i,
  input  logic [DW-1:0] trail_i,
  output logic          pulse_o,
  output logic          pin_o
);
  // An empty or reversed window never satisfies lead <= t < trail.
  assign pulse_o = run_i && !inh_i && in_win(32'(tcnt_i), 32'(lead_i), 32'(trail_i));
  assign pin_o   = pulse_o ^ pol_i;
endmodule

// File: rtl/dly_pulse_core.sv
`timescale 1ns/1ps
module dly_pulse_core import dly_pkg::*; #(
  parameter int DW       = 16,
  parameter int LAT_CYC  = 9,
  parameter int HOLD_CYC = 10,
  parameter int TAIL_CYC = 3,
  parameter int STB_CYC  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [NCH*DW-1:0] dly_i,
  input  logic [NPAIR-1:0]  pol_i,
  input  logic              inh_i,
  output logic              t0_o,
  output logic              busy_o,
  output logic [NPAIR-1:0]  pair_o,
  output logic [NCH-1:0]    lvl_o,
  output logic [NCH-1:0]    stb_o,
  output logic [NCMB-1:0]   cmb_o
);
  logic              run;
  logic [DW:0]       tcnt;
  logic [NCH*DW-1:0] cap_dly;
  logic [DW-1:0]     maxd;
  logic [NPAIR-1:0]  pulse;

  dly_seq #(.DW(DW), .LAT_CYC(LAT_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .dly_i(dly_i),
    .run_o(run), .busy_o(busy_o), .tcnt_o(tcnt), .cap_o(cap_dly), .maxd_o(maxd)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    dly_chan #(.DW(DW), .TAIL_CYC(TAIL_CYC), .STB_CYC(STB_CYC)) u_chan (
      .run_i(run), .inh_i(inh_i), .tcnt_i(tcnt), .dly_i(cap_dly[n*DW +: DW]),
      .maxd_i(maxd), .lvl_o(lvl_o[n]), .stb_o(stb_o[n])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    dly_pair #(.DW(DW)) u_pair (
      .run_i(run), .inh_i(inh_i), .pol_i(pol_i[p]), .tcnt_i(tcnt),
      .lead_i(cap_dly[(2*p)*DW +: DW]), .trail_i(cap_dly[(2*p+1)*DW +: DW]),
      .pulse_o(pulse[p]), .pin_o(pair_o[p])
    );
  end

  assign cmb_o[0] = pulse[0] | pulse[1];
  assign cmb_o[1] = pulse[2] | pulse[3];
  assign cmb_o[2] = pulse[0] | pulse[1] | pulse[2];
  assign cmb_o[3] = |pulse;
  assign t0_o     = run;
endmodule

// File: rtl/dly_pulse_core_chk.sv
`timescale 1ns/1ps
module dly_pulse_core_chk import dly_pkg::*; #(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic              busy_o,
  input logic              t0_o,
  input logic              inh_i,
  input logic [NPAIR-1:0]  pol_i,
  input logic [NPAIR-1:0]  pair_o,
  input logic [NCH-1:0]    lvl_o,
  input logic [NCH-1:0]    stb_o,
  input logic [NCMB-1:0]   cmb_o,
  input logic [NCH*DW-1:0] cap_dly
);
  a_r1_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !busy_o) |=> (busy_o && !t0_o));

  a_r1_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || $stable(cap_dly)));

  a_r3_t0_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    t0_o |-> busy_o);

  a_r3_end_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(t0_o) |-> !busy_o);

  a_r5_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
    !t0_o |-> (pair_o == pol_i));

  a_r6_lvl_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_o) |-> t0_o);

  a_r7_stb_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_o) |-> t0_o);

  a_r8_cmb_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb_o[0] |-> cmb_o[2]) and (cmb_o[2] |-> cmb_o[3]) and (cmb_o[1] |-> cmb_o[3]));

  a_r9_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    inh_i |-> ((pair_o == pol_i) && (lvl_o == '0) && (stb_o == '0) && (cmb_o == '0)));
endmodule

bind dly_pulse_core dly_pulse_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .busy_o(busy_o), .t0_o(t0_o),
  .inh_i(inh_i), .pol_i(pol_i), .pair_o(pair_o), .lvl_o(lvl_o), .stb_o(stb_o),
  .cmb_o(cmb_o), .cap_dly(cap_dly)
);

// File: tb/dly_pulse_core_bench.sv
`timescale 1ns/1ps
module dly_pulse_core_bench;
  localparam int DW = 16, LAT = 9, HOLD = 10, TAIL = 3, STB = 10;

  typedef struct {
    logic       t0;
    logic       busy;
    logic [3:0] pair;
    logic [7:0] lvl;
    logic [7:0] stb;
    logic [3:0] cmb;
    int         k;
    string      tag;
  } exp_t;

  logic          clk = 0, rst_n = 0, trig_i = 0, inh_i = 0;
  logic [8*DW-1:0] dly_i = '0;
  logic [3:0]    pol_i = '0;
  logic          t0_o, busy_o;
  logic [3:0]    pair_o, cmb_o;
  logic [7:0]    lvl_o, stb_o;

  exp_t sbq[$];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  dly_pulse_core #(.DW(DW), .LAT_CYC(LAT), .HOLD_CYC(HOLD), .TAIL_CYC(TAIL),
                   .STB_CYC(STB)) u_dly_pulse_core (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .dly_i(dly_i), .pol_i(pol_i),
    .inh_i(inh_i), .t0_o(t0_o), .busy_o(busy_o), .pair_o(pair_o), .lvl_o(lvl_o),
    .stb_o(stb_o), .cmb_o(cmb_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp,
                     input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s k=%0d actual=%0h expected=%0h", req, k, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle and compares mid-cycle.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk({"R2/R3 t0 ", e.tag}, {7'd0, t0_o}, {7'd0, e.t0}, e.k);
      chk({"R1/R3 busy ", e.tag}, {7'd0, busy_o}, {7'd0, e.busy}, e.k);
      chk({"R4/R5 pair ", e.tag}, {4'd0, pair_o}, {4'd0, e.pair}, e.k);
      chk({"R6 lvl ", e.tag}, lvl_o, e.lvl, e.k);
      chk({"R7 stb ", e.tag}, stb_o, e.stb, e.k);
      chk({"R8 cmb ", e.tag}, {4'd0, cmb_o}, {4'd0, e.cmb}, e.k);
    end
  end

  // Driver: fires one trigger, predicts the whole cycle, optionally pokes mid-cycle.
  task automatic fire(input int d[8], input logic [3:0] pol, input logic inh,
                      input int poke_at, input string tag);
    int mx, last;
    mx = 0;
    foreach (d[i]) if (d[i] > mx) mx = d[i];
    for (int i = 0; i < 8; i++) dly_i[i*DW +: DW] = DW'(d[i]);
    pol_i = pol;
    inh_i = inh;
    @(negedge clk);
    trig_i = 1;
    @(posedge clk);
    #1;
    trig_i = 0;
    last = LAT + mx + HOLD + 1;            // first idle sample after the cycle
    for (int k = 1; k <= last; k++) begin
      exp_t e;
      int t;
      logic on;
      logic [3:0] pp;
      t = k - LAT - 1;                     // time relative to T0 rise
      on = (t >= 0) && (t <= mx + HOLD - 1);
      e.t0 = on;
      e.busy = (k < last);
      for (int n = 0; n < 8; n++) begin
        int fall_lvl, fall_stb;
        fall_lvl = mx + TAIL;
        fall_stb = d[n] + STB;
        e.lvl[n] = on && !inh && (t >= d[n]) && (t < fall_lvl);
        e.stb[n] = on && !inh && (t >= d[n]) && (t < fall_stb);
      end
      for (int p = 0; p < 4; p++)
        pp[p] = on && !inh && (d[2*p+1] > d[2*p]) && (t >= d[2*p]) && (t < d[2*p+1]);
      e.pair = pp ^ pol;
      e.cmb  = {pp[0] | pp[1] | pp[2] | pp[3], pp[0] | pp[1] | pp[2],
                pp[2] | pp[3], pp[0] | pp[1]};
      e.k = k;
      e.tag = tag;
      sbq.push_back(e);
    end
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      trig_i = 1;                          // R1: ignored while busy
      for (int i = 0; i < 8; i++) dly_i[i*DW +: DW] = DW'(7);
      @(negedge clk);
      trig_i = 0;
    end
    wait (sbq.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10 t0", {7'd0, t0_o}, 8'd0, 0);
    chk("R10 busy", {7'd0, busy_o}, 8'd0, 0);
    chk("R10 pair", {4'd0, pair_o}, 8'd0, 0);
    chk("R10 lvl", lvl_o, 8'd0, 0);
    chk("R10 stb", stb_o, 8'd0, 0);
    chk("R10 cmb", {4'd0, cmb_o}, 8'd0, 0);
    // R4: CD equal delays and EF reversed give no pulse
    fire('{3, 8, 10, 10, 20, 12, 0, 5}, 4'b0000, 1'b0, 0, "R4 mixed");
    // R5: inverted polarity on CD and GH
    fire('{1, 6, 4, 30, 2, 9, 12, 14}, 4'b1010, 1'b0, 0, "R5 polarity");
    // R9: inhibit keeps pulses off but T0 runs
    fire('{1, 6, 4, 30, 2, 9, 12, 14}, 4'b0110, 1'b1, 0, "R9 inhibit");
    // R3/R6: all-zero delays, shortest cycle
    fire('{0, 0, 0, 0, 0, 0, 0, 0}, 4'b0000, 1'b0, 0, "R3 zero");
    // R1: retrigger and delay rewrite during the cycle are ignored
    fire('{2, 5, 5, 9, 11, 16, 18, 25}, 4'b0001, 1'b0, 12, "R1 poke");
    // R8/R3: back-to-back cycle right after the previous one
    fire('{0, 40, 2, 4, 6, 8, 10, 12}, 4'b0000, 1'b0, 0, "R8 combine");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule